// File: doc/BRIEF.md
# Asynchronous Fetch-and-Add Command Front End

This block takes one packed 64-bit command word that asks for an atomic add with no wait on the issuing side. It splits the word into its fields and checks the length and alignment fields. A command that passes is forwarded as a single request to a fetch-and-add backend. When the backend answers with the register's previous contents, the block sign-extends that value to the operand width and writes it as one 64-bit word into an 8-byte slot of a local scratch memory. A one-cycle done strobe marks that write.

Commands may ask to wait for a pending tag switch. When the backend reports that such a wait timed out, the stored word carries a set top bit as its error flag, and its lower 63 bits are forced to zero. Only one command is in flight at a time, and `cmd_ready` applies back-pressure. A malformed command is discarded and raises a sticky error bit that only reset clears.

Top module: `fau_async_cmd`

## Requirements
- R1: The scratch slot index is command bits 63:56, and `spm_wr_addr` equals that index times 8. Command bits 10:0 give the register byte address, bits 12:11 the size code and bit 13 the tag-wait flag. These three fields appear unchanged on `be_req_reg`, `be_req_size` and `be_req_tagwait`.
- R2: Command bits 35:14 hold a signed 22-bit increment. It is presented sign-extended to 64 bits on `be_req_incr`.
- R3: A command whose length field (bits 55:48) is not 1 is dropped. It makes no backend request and no scratch write, and it sets `err_sticky`.
- R4: Size codes 0/1/2/3 select 8/16/32/64-bit operands. A command whose register address has any of its low 0/1/2/3 bits set is misaligned and is dropped like an R3 command.
- R5: Once set, `err_sticky` stays high through later good commands until reset.
- R6: The backend's returned value is sign-extended from the operand width (bits 7:0, 15:0, 31:0 or 63:0) before it is written to scratch.
- R7: For a tag-wait command answered with `be_rsp_timeout` high, the written word is 0x8000_0000_0000_0000.
- R8: When the tag-wait flag is 0, `be_rsp_timeout` is ignored and the data is written as in R6.
- R9: One command at a time. `cmd_ready` is low from the cycle after a good command is accepted until the cycle of its scratch write.
- R10: `be_req_valid` stays high with unchanged request fields until the cycle `be_req_ready` is seen high.
- R11: `done` pulses for one cycle, in the same cycle as `spm_wr_en`. That cycle follows the one in which `be_rsp_valid` arrived, and it occurs once per good command.
- R12: After reset, `cmd_ready` is 1 and `be_req_valid`, `spm_wr_en`, `done` and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 64 | Packed command |
| cmd_ready | output | 1 | Block can accept a command |
| be_req_valid | output | 1 | Backend request valid |
| be_req_ready | input | 1 | Backend takes the request |
| be_req_reg | output | 11 | Register byte address |
| be_req_size | output | 2 | Size code |
| be_req_tagwait | output | 1 | Wait for tag switch |
| be_req_incr | output | 64 | Sign-extended increment |
| be_rsp_valid | input | 1 | Backend response valid |
| be_rsp_data | input | 64 | Previous register value, raw |
| be_rsp_timeout | input | 1 | Tag-wait timed out |
| spm_wr_en | output | 1 | Scratch write strobe |
| spm_wr_addr | output | 11 | Scratch byte address, 8-byte aligned |
| spm_wr_data | output | 64 | Scratch write word |
| done | output | 1 | Command completion pulse |
| err_sticky | output | 1 | A command was dropped |

## Verification
The bench sends all four size codes with returned values whose sign bit sits just above or just below the operand width. It places unrelated bits above the operand, which separates correct sign extension from plain pass-through or masking. Tag-wait and plain commands are each paired with the timeout input both high and low, which shows whether the error word is gated by the flag. Commands with a length of 0 and of 2, and with misaligned addresses, are checked for silence at the backend and scratch ports. Request stalls of zero to two cycles probe holding of the request and back-pressure.

// File: rtl/fau_async_pkg.sv
package fau_async_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } op_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fau_cmd_decode.sv
module fau_cmd_decode
  import fau_async_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int SLOT_W = 8,
  parameter int LEN_W  = 8,
  parameter int REG_AW = 11,
  parameter int INCR_W = 22
) (
  input  logic [WORD_W-1:0] cmd,
  output logic [SLOT_W-1:0] slot,
  output logic [REG_AW-1:0] reg_addr,
  output op_size_e          size,
  output logic              tagwait,
  output logic [WORD_W-1:0] incr,
  output logic              cmd_ok
);
  localparam int SLOT_LO = WORD_W - SLOT_W;
  localparam int LEN_LO  = SLOT_LO - LEN_W;
  localparam int SIZE_LO = REG_AW;
  localparam int TW_BIT  = REG_AW + 2;
  localparam int INCR_LO = TW_BIT + 1;

  logic [LEN_W-1:0]  len_f;
  logic [INCR_W-1:0] incr_f;
  logic              misaligned;

  always_comb begin
    slot     = cmd[WORD_W-1:SLOT_LO];
    len_f    = cmd[SLOT_LO-1:LEN_LO];
    incr_f   = cmd[INCR_LO+INCR_W-1:INCR_LO];
    tagwait  = cmd[TW_BIT];
    size     = op_size_e'(cmd[SIZE_LO+1:SIZE_LO]);
    reg_addr = cmd[REG_AW-1:0];
    incr     = {{(WORD_W-INCR_W){incr_f[INCR_W-1]}}, incr_f};
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = reg_addr[0];
      SZ_WORD: misaligned = |reg_addr[1:0];
      default: misaligned = |reg_addr[2:0];
    endcase
    cmd_ok = (len_f == LEN_W'(1)) && !misaligned;
  end
endmodule

// File: rtl/fau_result_fmt.sv
module fau_result_fmt
  import fau_async_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  op_size_e          size,
  input  logic              tagwait,
  input  logic              timeout,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    if (tagwait && timeout) begin
      word = {1'b1, {(WORD_W-1){1'b0}}};
    end else begin
      case (size)
        SZ_BYTE: word = {{(WORD_W-8){raw[7]}},   raw[7:0]};
        SZ_HALF: word = {{(WORD_W-16){raw[15]}}, raw[15:0]};
        SZ_WORD: word = {{(WORD_W-32){raw[31]}}, raw[31:0]};
        default: word = raw;
      endcase
    end
  end
endmodule

// File: rtl/fau_seq_ctrl.sv
module fau_seq_ctrl
  import fau_async_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int SLOT_W = 8,
  parameter int REG_AW = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic                cmd_ok,
  input  logic [SLOT_W-1:0]   d_slot,
  input  logic [REG_AW-1:0]   d_reg,
  input  op_size_e            d_size,
  input  logic                d_tagwait,
  input  logic [WORD_W-1:0]   d_incr,
  output logic                cmd_ready,
  output logic                be_req_valid,
  input  logic                be_req_ready,
  output logic [REG_AW-1:0]   q_reg,
  output op_size_e            q_size,
  output logic                q_tagwait,
  output logic [WORD_W-1:0]   q_incr,
  input  logic                be_rsp_valid,
  input  logic [WORD_W-1:0]   fmt_word,
  output logic                spm_wr_en,
  output logic [SLOT_W+2:0]   spm_wr_addr,
  output logic [WORD_W-1:0]   spm_wr_data,
  output logic                done,
  output logic                err_sticky
);
  seq_state_e state;

  assign cmd_ready    = (state == ST_IDLE);
  assign be_req_valid = (state == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      spm_wr_en  <= 1'b0;
      done       <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      spm_wr_en <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          if (cmd_ok) state <= ST_ISSUE;
          else        err_sticky <= 1'b1;
        end
        ST_ISSUE: if (be_req_ready) state <= ST_WAIT;
        ST_WAIT: if (be_rsp_valid) begin
          spm_wr_en <= 1'b1;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Datapath registers without reset, loaded on accept or response.
  always_ff @(posedge clk) begin
    if (state == ST_IDLE && cmd_valid && cmd_ok) begin
      q_reg       <= d_reg;
      q_size      <= d_size;
      q_tagwait   <= d_tagwait;
      q_incr      <= d_incr;
      spm_wr_addr <= {d_slot, 3'b000};
    end
    if (state == ST_WAIT && be_rsp_valid) spm_wr_data <= fmt_word;
  end
endmodule

// File: rtl/fau_async_cmd.sv
module fau_async_cmd
  import fau_async_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int SLOT_W = 8,
  parameter int LEN_W  = 8,
  parameter int REG_AW = 11,
  parameter int INCR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [63:0]       cmd_word,
  output logic              cmd_ready,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic [10:0]       be_req_reg,
  output logic [1:0]        be_req_size,
  output logic              be_req_tagwait,
  output logic [63:0]       be_req_incr,
  input  logic              be_rsp_valid,
  input  logic [63:0]       be_rsp_data,
  input  logic              be_rsp_timeout,
  output logic              spm_wr_en,
  output logic [10:0]       spm_wr_addr,
  output logic [63:0]       spm_wr_data,
  output logic              done,
  output logic              err_sticky
);
  logic [SLOT_W-1:0] d_slot;
  logic [REG_AW-1:0] d_reg;
  op_size_e          d_size, q_size;
  logic              d_tagwait, cmd_ok;
  logic [WORD_W-1:0] d_incr, fmt_word;

  fau_cmd_decode #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W),
                   .REG_AW(REG_AW), .INCR_W(INCR_W)) u_dec (
    .cmd(cmd_word), .slot(d_slot), .reg_addr(d_reg), .size(d_size),
    .tagwait(d_tagwait), .incr(d_incr), .cmd_ok(cmd_ok)
  );

  fau_result_fmt #(.WORD_W(WORD_W)) u_fmt (
    .size(q_size), .tagwait(be_req_tagwait), .timeout(be_rsp_timeout),
    .raw(be_rsp_data), .word(fmt_word)
  );

  fau_seq_ctrl #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .REG_AW(REG_AW)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ok(cmd_ok),
    .d_slot(d_slot), .d_reg(d_reg), .d_size(d_size), .d_tagwait(d_tagwait),
    .d_incr(d_incr), .cmd_ready(cmd_ready), .be_req_valid(be_req_valid),
    .be_req_ready(be_req_ready), .q_reg(be_req_reg), .q_size(q_size),
    .q_tagwait(be_req_tagwait), .q_incr(be_req_incr),
    .be_rsp_valid(be_rsp_valid), .fmt_word(fmt_word),
    .spm_wr_en(spm_wr_en), .spm_wr_addr(spm_wr_addr),
    .spm_wr_data(spm_wr_data), .done(done), .err_sticky(err_sticky)
  );

  assign be_req_size = q_size;
endmodule

// File: rtl/fau_async_cmd_chk.sv
module fau_async_cmd_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_ready,
  input logic        be_req_valid,
  input logic        be_req_ready,
  input logic [10:0] be_req_reg,
  input logic [1:0]  be_req_size,
  input logic [63:0] be_req_incr,
  input logic        be_rsp_valid,
  input logic        spm_wr_en,
  input logic        done,
  input logic        err_sticky
);
  logic aligned;
  always_comb begin
    case (be_req_size)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = !be_req_reg[0];
      2'd2:    aligned = !(|be_req_reg[1:0]);
      default: aligned = !(|be_req_reg[2:0]);
    endcase
  end

  assert_req_blocks_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    be_req_valid |-> !cmd_ready);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (be_req_valid && !be_req_ready) |=>
      (be_req_valid && $stable(be_req_reg) && $stable(be_req_size) && $stable(be_req_incr)));

  assert_req_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    be_req_valid |-> aligned);

  assert_done_after_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(be_rsp_valid));

  assert_done_with_write_R11: assert property (@(posedge clk) disable iff (rst)
    done == spm_wr_en);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
endmodule

bind fau_async_cmd fau_async_cmd_chk u_chk (.*);

// File: tb/fau_async_cmd_bench.sv
module fau_async_cmd_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [63:0] cmd_word = '0;
  logic        cmd_ready, be_req_valid, be_req_tagwait;
  logic        be_req_ready = 1'b0;
  logic [10:0] be_req_reg, spm_wr_addr;
  logic [1:0]  be_req_size;
  logic [63:0] be_req_incr, spm_wr_data;
  logic        be_rsp_valid = 1'b0, be_rsp_timeout = 1'b0;
  logic [63:0] be_rsp_data = '0;
  logic        spm_wr_en, done, err_sticky;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fau_async_cmd u_fau_async_cmd (.*);

  typedef struct packed {
    logic [7:0]  slot;
    logic [21:0] incr;
    logic        tw;
    logic [1:0]  sz;
    logic [10:0] rg;
    logic [63:0] rsp;
    logic        to;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h05, 22'h000003, 1'b0, 2'd0, 11'h007, 64'hAAAA_AAAA_AAAA_AA7F, 1'b0, 64'h0000_0000_0000_007F},
    '{8'h11, 22'h3FFFFF, 1'b0, 2'd0, 11'h003, 64'h0000_0000_0000_0080, 1'b0, 64'hFFFF_FFFF_FFFF_FF80},
    '{8'hFF, 22'h200000, 1'b0, 2'd1, 11'h00A, 64'h1234_5678_9ABC_8001, 1'b0, 64'hFFFF_FFFF_FFFF_8001},
    '{8'h00, 22'h1FFFFF, 1'b0, 2'd2, 11'h7FC, 64'h5555_5555_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF},
    '{8'h42, 22'h000100, 1'b0, 2'd2, 11'h010, 64'hDEAD_BEEF_8000_0000, 1'b0, 64'hFFFF_FFFF_8000_0000},
    '{8'h80, 22'h3FFFF0, 1'b0, 2'd3, 11'h7F8, 64'h8123_4567_89AB_CDEF, 1'b0, 64'h8123_4567_89AB_CDEF},
    '{8'h07, 22'h000001, 1'b1, 2'd1, 11'h002, 64'h0000_0000_0000_1234, 1'b1, 64'h8000_0000_0000_0000},
    '{8'h09, 22'h000002, 1'b0, 2'd2, 11'h004, 64'h0000_0000_0000_0042, 1'b1, 64'h0000_0000_0000_0042},
    '{8'h0A, 22'h000005, 1'b1, 2'd3, 11'h008, 64'h0000_0000_0000_0099, 1'b0, 64'h0000_0000_0000_0099}
  };

  function automatic logic [63:0] mk_cmd(logic [7:0] slot, logic [7:0] len, logic [21:0] incr,
                                         logic tw, logic [1:0] sz, logic [10:0] rg);
    return {slot, len, 12'h000, incr, tw, sz, rg};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one well-formed command through the request, response and write phases.
  task automatic run_good(input vec_t v, input int stall);
    logic [63:0] exp_incr;
    exp_incr = {{42{v.incr[21]}}, v.incr};
    @(negedge clk);
    cmd_word  = mk_cmd(v.slot, 8'd1, v.incr, v.tw, v.sz, v.rg);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(be_req_valid == 1'b1, "R10 request raised", 64'(be_req_valid), 64'd1);
    chk(cmd_ready == 1'b0, "R9 busy", 64'(cmd_ready), 64'd0);
    chk(be_req_reg == v.rg && be_req_size == v.sz && be_req_tagwait == v.tw, "R1 request fields",
        64'({be_req_tagwait, be_req_size, be_req_reg}), 64'({v.tw, v.sz, v.rg}));
    chk(be_req_incr == exp_incr, "R2 increment", be_req_incr, exp_incr);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(be_req_valid == 1'b1 && be_req_reg == v.rg && be_req_incr == exp_incr,
          "R10 hold while stalled", 64'(be_req_valid), 64'd1);
    end
    be_req_ready = 1'b1;
    @(negedge clk);
    be_req_ready = 1'b0;
    chk(be_req_valid == 1'b0, "R10 request dropped after ready", 64'(be_req_valid), 64'd0);
    chk(cmd_ready == 1'b0, "R9 busy while waiting", 64'(cmd_ready), 64'd0);
    chk(spm_wr_en == 1'b0 && done == 1'b0, "R11 no early write", 64'(spm_wr_en), 64'd0);
    be_rsp_valid   = 1'b1;
    be_rsp_data    = v.rsp;
    be_rsp_timeout = v.to;
    @(negedge clk);
    be_rsp_valid   = 1'b0;
    be_rsp_data    = 64'h0BAD_0BAD_0BAD_0BAD;
    be_rsp_timeout = 1'b0;
    chk(spm_wr_en == 1'b1 && done == 1'b1, "R11 write with done", 64'({spm_wr_en, done}), 64'd3);
    chk(spm_wr_addr == {v.slot, 3'b000}, "R1 slot address", 64'(spm_wr_addr), 64'({v.slot, 3'b000}));
    if (v.tw && v.to)      chk(spm_wr_data == v.exp, "R7 timeout word", spm_wr_data, v.exp);
    else if (v.to)         chk(spm_wr_data == v.exp, "R8 timeout ignored", spm_wr_data, v.exp);
    else                   chk(spm_wr_data == v.exp, "R6 sign extension", spm_wr_data, v.exp);
    chk(cmd_ready == 1'b1, "R9 ready at write", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    chk(spm_wr_en == 1'b0 && done == 1'b0, "R11 single pulse", 64'({spm_wr_en, done}), 64'd0);
  endtask

  // Presents a command expected to be discarded and watches the ports stay quiet.
  task automatic run_drop(input logic [63:0] c, input string req);
    @(negedge clk);
    cmd_word  = c;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(be_req_valid == 1'b0 && spm_wr_en == 1'b0 && done == 1'b0, req,
          64'({be_req_valid, spm_wr_en, done}), 64'd0);
      @(negedge clk);
    end
    chk(err_sticky == 1'b1 && cmd_ready == 1'b1, req, 64'({err_sticky, cmd_ready}), 64'd3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && be_req_valid == 1'b0 && spm_wr_en == 1'b0 && done == 1'b0 &&
        err_sticky == 1'b0, "R12 reset state",
        64'({cmd_ready, be_req_valid, spm_wr_en, done, err_sticky}), 64'h10);

    for (int i = 0; i < NV; i++) run_good(VEC[i], i % 3);
    chk(err_sticky == 1'b0, "R3 R4 no error on good commands", 64'(err_sticky), 64'd0);

    run_drop(mk_cmd(8'h01, 8'd0, 22'h1, 1'b0, 2'd0, 11'h001), "R3 length zero dropped");
    run_good(VEC[0], 1);
    chk(err_sticky == 1'b1, "R5 sticky after good command", 64'(err_sticky), 64'd1);
    run_drop(mk_cmd(8'h01, 8'd2, 22'h1, 1'b0, 2'd3, 11'h008), "R3 length two dropped");
    run_drop(mk_cmd(8'h02, 8'd1, 22'h1, 1'b0, 2'd3, 11'h004), "R4 misaligned double dropped");
    run_drop(mk_cmd(8'h02, 8'd1, 22'h1, 1'b0, 2'd1, 11'h005), "R4 misaligned half dropped");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(err_sticky == 1'b0 && cmd_ready == 1'b1, "R12 R5 reset clears error",
        64'({err_sticky, cmd_ready}), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule